// File: doc/BRIEF.md
# Paged Configuration Register Aperture

This block is a 32-bit memory-mapped slave that lets a narrow 4 KB bus aperture reach a configuration space of up to 64 KB. The lower part of the aperture, from offset 0x000 up to 0xBFF, maps one-to-one onto the internal space. The top kilobyte, offsets 0xC00 to 0xFFF, is a movable window. A 6-bit page field chooses which 1 KB page of the internal space that window shows.

The page field lives in a bridge control register at offset 0x808. The block holds that register itself. The register also carries two path-enable bits, which drive output pins. Software moves the window with a read-modify-write of this register. Because the register lies in the direct region, it stays reachable whatever page is selected.

Every other access is passed once to a generic internal register-array port. That port returns read data and a hit flag. A response always comes back, even when the internal offset is not implemented.

Top module: `cfg_page_aperture`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` and `cfg_en` are 0. A read of the control register at 0x808 returns 0, so page 0 is selected and both path enables are off.
- R2: A bus offset below 0xC00, other than 0x808, reaches internal offset equal to the bus offset, with the upper 4 bits zero. The page field has no effect on it.
- R3: A bus offset from 0xC00 to 0xFFF reaches internal offset `page * 1024 + bus_addr[9:0]`, where page is control register bits 18:13.
- R4: The control register at 0x808 is served inside the block and never raises `cfg_en`. Bits 0, 1 and 18:13 are read/write. Bit 0 drives `out_pio_en` and bit 1 drives `in_pio_en`. All other bits read as 0.
- R5: A write to the page field takes effect for the next accepted access.
- R6: When `cfg_hit` is 0 during the strobe, a read returns 0 and a write is still answered with a response. The bus never hangs.
- R7: A request is accepted when `req_valid` and `req_ready` are both 1. `cfg_en` is high for exactly the one cycle after acceptance. `resp_valid` is high for exactly the cycle after that. `req_ready` is 0 from acceptance until the response cycle ends.
- R8: For a forwarded access, `cfg_we` equals the request's write flag and `cfg_wdata` equals its write data. A read that hits returns `cfg_rdata` on `resp_rdata`.
- R9: A read-modify-write of the control register keeps every writable bit outside 18:13. Writing 0xFFFFFFFF reads back as 0x0007E003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the aperture |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response cycle |
| resp_rdata | output | 32 | Read data (0 for writes and misses) |
| cfg_en | output | 1 | Internal access strobe |
| cfg_we | output | 1 | Internal write enable |
| cfg_addr | output | 16 | Internal byte offset |
| cfg_wdata | output | 32 | Internal write data |
| cfg_rdata | input | 32 | Internal read data, valid while `cfg_en` is high |
| cfg_hit | input | 1 | Internal offset is implemented |
| out_pio_en | output | 1 | Control register bit 0 |
| in_pio_en | output | 1 | Control register bit 1 |

## Verification
Each accepted request has fixed timing. The internal strobe, with its offset, write flag and write data, appears in the first cycle after the accepting edge. The response appears in the second cycle. The block is ready again in the third cycle.

The bench drives a request just after a falling edge and lets the next rising edge accept it. It then reads the strobe fields at the following falling edge and the response at the falling edge after that. So every sample lands mid-cycle in the exact cycle a result is due.

The control register's answer follows the same two-cycle rule. That is why a page written by one transaction is visible to the very next one.

// File: rtl/pca_pkg.sv
// Shared types for the paged configuration aperture.
// Assumes a single outstanding transaction at a time.
package pca_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } pca_state_e;
endpackage

// File: rtl/pca_decode.sv
// Address decode: turns a bus offset and the current page into an internal
// offset, and flags the locally held control register.
// Assumes INT_AW = PAGE_W + WIN_W and INT_AW > BUS_AW.
module pca_decode #(
    parameter int BUS_AW = 12,
    parameter int PAGE_W = 6,
    parameter int WIN_W  = 10,
    parameter int INT_AW = 16,
    parameter logic [BUS_AW-1:0] DIRECT_LIMIT = 'hC00,
    parameter logic [BUS_AW-1:0] CTRL_OFF     = 'h808
) (
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [PAGE_W-1:0] page,
    output logic              is_ctrl,
    output logic [INT_AW-1:0] int_addr
);
    localparam int PAD_W = INT_AW - BUS_AW;

    // Steer the offset: direct pass-through below the limit, paged above.
    always_comb begin
        is_ctrl = (bus_addr == CTRL_OFF);
        if (bus_addr >= DIRECT_LIMIT) begin
            int_addr = {page, bus_addr[WIN_W-1:0]};
        end else begin
            int_addr = {{PAD_W{1'b0}}, bus_addr};
        end
    end
endmodule

// File: rtl/pca_ctrl_reg.sv
// Bridge control register: holds the page field and two path enables.
// Unimplemented bits are not stored and read as zero.
module pca_ctrl_reg #(
    parameter int DW       = 32,
    parameter int PAGE_W   = 6,
    parameter int PAGE_LSB = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [PAGE_W-1:0] page,
    output logic              out_en,
    output logic              in_en
);
    localparam logic [DW-1:0] PAGE_MASK = {{(DW-PAGE_W){1'b0}}, {PAGE_W{1'b1}}} << PAGE_LSB;
    localparam logic [DW-1:0] RW_MASK   = PAGE_MASK | {{(DW-2){1'b0}}, 2'b11};

    logic [DW-1:0] reg_q;

    // Store writable bits only; reset clears page and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (wr_en) begin
            reg_q <= wdata & RW_MASK;
        end
    end

    // Break out the fields.
    always_comb begin
        rdata  = reg_q;
        page   = reg_q[PAGE_LSB +: PAGE_W];
        out_en = reg_q[0];
        in_en  = reg_q[1];
    end
endmodule

// File: rtl/pca_seq.sv
// Access sequencer: accepts one request, issues one strobe cycle to the
// internal port (or to the control register), then one response cycle.
// Assumes the internal port answers combinationally during the strobe.
module pca_seq #(
    parameter int DW     = 32,
    parameter int INT_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DW-1:0]     req_wdata,
    input  logic              is_ctrl,
    input  logic [INT_AW-1:0] int_addr,
    input  logic [DW-1:0]     ctrl_rdata,
    input  logic [DW-1:0]     cfg_rdata,
    input  logic              cfg_hit,
    output logic              req_ready,
    output logic              cfg_en,
    output logic              cfg_we,
    output logic [INT_AW-1:0] cfg_addr,
    output logic [DW-1:0]     cfg_wdata,
    output logic              ctrl_wr,
    output logic              resp_valid,
    output logic [DW-1:0]     resp_rdata
);
    import pca_pkg::*;

    pca_state_e        state_q;
    logic              we_q;
    logic              ctrl_q;
    logic [INT_AW-1:0] addr_q;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     rdata_q;

    // Sequence states and latch the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            we_q    <= 1'b0;
            ctrl_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q <= ST_ISSUE;
                        we_q    <= req_write;
                        ctrl_q  <= is_ctrl;
                        addr_q  <= int_addr;
                        wdata_q <= req_wdata;
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_RESP;
                    if (we_q) begin
                        rdata_q <= '0;
                    end else if (ctrl_q) begin
                        rdata_q <= ctrl_rdata;
                    end else if (cfg_hit) begin
                        rdata_q <= cfg_rdata;
                    end else begin
                        rdata_q <= '0;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Drive the strobe, control write and response from state.
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        cfg_en     = (state_q == ST_ISSUE) && !ctrl_q;
        cfg_we     = cfg_en && we_q;
        cfg_addr   = addr_q;
        cfg_wdata  = wdata_q;
        ctrl_wr    = (state_q == ST_ISSUE) && ctrl_q && we_q;
        resp_valid = (state_q == ST_RESP);
        resp_rdata = rdata_q;
    end
endmodule

// File: rtl/cfg_page_aperture.sv
// Paged configuration aperture top: 4 KB bus aperture onto a 64 KB internal
// space; the top 1 KB is a window whose page comes from a control register.
// Assumes word-aligned accesses; byte offset bits pass through unchanged.
module cfg_page_aperture #(
    parameter int DW       = 32,
    parameter int BUS_AW   = 12,
    parameter int PAGE_W   = 6,
    parameter int WIN_W    = 10,
    parameter int PAGE_LSB = 13,
    parameter logic [BUS_AW-1:0] DIRECT_LIMIT = 'hC00,
    parameter logic [BUS_AW-1:0] CTRL_OFF     = 'h808
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [BUS_AW-1:0]         req_addr,
    input  logic [DW-1:0]             req_wdata,
    output logic                      resp_valid,
    output logic [DW-1:0]             resp_rdata,
    output logic                      cfg_en,
    output logic                      cfg_we,
    output logic [PAGE_W+WIN_W-1:0]   cfg_addr,
    output logic [DW-1:0]             cfg_wdata,
    input  logic [DW-1:0]             cfg_rdata,
    input  logic                      cfg_hit,
    output logic                      out_pio_en,
    output logic                      in_pio_en
);
    localparam int INT_AW = PAGE_W + WIN_W;

    logic              is_ctrl;
    logic [INT_AW-1:0] int_addr;
    logic [PAGE_W-1:0] page;
    logic [DW-1:0]     ctrl_rdata;
    logic              ctrl_wr;

    pca_decode #(
        .BUS_AW(BUS_AW), .PAGE_W(PAGE_W), .WIN_W(WIN_W), .INT_AW(INT_AW),
        .DIRECT_LIMIT(DIRECT_LIMIT), .CTRL_OFF(CTRL_OFF)
    ) u_decode (
        .bus_addr(req_addr),
        .page(page),
        .is_ctrl(is_ctrl),
        .int_addr(int_addr)
    );

    pca_ctrl_reg #(
        .DW(DW), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB)
    ) u_ctrl (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(ctrl_wr),
        .wdata(cfg_wdata),
        .rdata(ctrl_rdata),
        .page(page),
        .out_en(out_pio_en),
        .in_en(in_pio_en)
    );

    pca_seq #(
        .DW(DW), .INT_AW(INT_AW)
    ) u_seq (
        .clk(clk),
        .rst_n(rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_wdata(req_wdata),
        .is_ctrl(is_ctrl),
        .int_addr(int_addr),
        .ctrl_rdata(ctrl_rdata),
        .cfg_rdata(cfg_rdata),
        .cfg_hit(cfg_hit),
        .req_ready(req_ready),
        .cfg_en(cfg_en),
        .cfg_we(cfg_we),
        .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata),
        .ctrl_wr(ctrl_wr),
        .resp_valid(resp_valid),
        .resp_rdata(resp_rdata)
    );
endmodule

// File: rtl/pca_aperture_checker.sv
// Protocol and decode properties for the paged aperture, bound to the top.
module pca_aperture_checker #(
    parameter int DW     = 32,
    parameter int BUS_AW = 12,
    parameter int WIN_W  = 10,
    parameter int INT_AW = 16,
    parameter logic [BUS_AW-1:0] DIRECT_LIMIT = 'hC00,
    parameter logic [BUS_AW-1:0] CTRL_OFF     = 'h808
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [BUS_AW-1:0] req_addr,
    input logic              cfg_en,
    input logic              cfg_we,
    input logic              cfg_hit,
    input logic [INT_AW-1:0] cfg_addr,
    input logic              resp_valid,
    input logic [DW-1:0]     resp_rdata
);
    logic acc;
    always_comb acc = req_valid && req_ready;

    p_ctrl_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr == CTRL_OFF) |=> !cfg_en);

    p_strobe_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr != CTRL_OFF) |=> cfg_en);

    p_resp_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (resp_valid && !cfg_en));

    p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en || resp_valid) |-> !req_ready);

    p_miss_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !cfg_we && !cfg_hit) |=> (resp_valid && resp_rdata == '0));

    p_window_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr >= DIRECT_LIMIT) |=>
        (cfg_addr[WIN_W-1:0] == $past(req_addr[WIN_W-1:0])));

    p_direct_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr < DIRECT_LIMIT && req_addr != CTRL_OFF) |=>
        (cfg_addr[BUS_AW-1:0] == $past(req_addr) && cfg_addr[INT_AW-1:BUS_AW] == '0));
endmodule

bind cfg_page_aperture pca_aperture_checker #(
    .DW(DW), .BUS_AW(BUS_AW), .WIN_W(WIN_W), .INT_AW(PAGE_W + WIN_W),
    .DIRECT_LIMIT(DIRECT_LIMIT), .CTRL_OFF(CTRL_OFF)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr(req_addr),
    .cfg_en(cfg_en),
    .cfg_we(cfg_we),
    .cfg_hit(cfg_hit),
    .cfg_addr(cfg_addr),
    .resp_valid(resp_valid),
    .resp_rdata(resp_rdata)
);

// File: tb/cfg_page_aperture_test.sv
module cfg_page_aperture_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [11:0] req_addr;
    logic [31:0] req_wdata;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        cfg_en, cfg_we;
    logic [15:0] cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        cfg_hit;
    logic        out_pio_en, in_pio_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfg_page_aperture uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_hit(cfg_hit),
        .out_pio_en(out_pio_en), .in_pio_en(in_pio_en)
    );

    // Internal array model: pages 0..15 exist; data is a pattern of the offset.
    always_comb begin
        cfg_hit   = (cfg_addr[15:14] == 2'b00);
        cfg_rdata = {16'hA5A5, cfg_addr};
    end

    logic        ob_en, ob_we, ob_busy, ob_resp;
    logic [15:0] ob_addr;
    logic [31:0] ob_wdata, ob_rdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xact(input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        ob_en = cfg_en; ob_we = cfg_we; ob_addr = cfg_addr;
        ob_wdata = cfg_wdata; ob_busy = !req_ready;
        @(negedge clk);
        ob_resp = resp_valid; ob_rdata = resp_rdata;
    endtask

    // page, bus offset, expected internal offset
    localparam logic [33:0] VEC [10] = '{
        {6'd0,  12'h000, 16'h0000},
        {6'd0,  12'h474, 16'h0474},
        {6'd0,  12'hBFC, 16'h0BFC},
        {6'd0,  12'hC00, 16'h0000},
        {6'd3,  12'hC04, 16'h0C04},
        {6'd3,  12'hFFC, 16'h0FFC},
        {6'd5,  12'hD20, 16'h1520},
        {6'd63, 12'hFFC, 16'hFFFC},
        {6'd63, 12'h100, 16'h0100},
        {6'd16, 12'hC00, 16'h4000}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 resp_valid", {31'd0, resp_valid}, 32'd0);
        chk("R1 cfg_en", {31'd0, cfg_en}, 32'd0);
        chk("R1 pio enables", {30'd0, in_pio_en, out_pio_en}, 32'd0);
        xact(1'b0, 12'h808, 32'd0);
        chk("R1 ctrl reset value", ob_rdata, 32'd0);
        chk("R4 ctrl read not forwarded", {31'd0, ob_en}, 32'd0);

        // R2 R3 R5 R6 R7: walk the vector table
        for (int i = 0; i < 10; i++) begin
            logic [5:0]  pg;
            logic [11:0] ba;
            logic [15:0] ia;
            logic [31:0] exp_rd;
            pg = VEC[i][33:28]; ba = VEC[i][27:16]; ia = VEC[i][15:0];
            xact(1'b1, 12'h808, {13'd0, pg, 13'd3});
            chk("R4 ctrl write not forwarded", {31'd0, ob_en}, 32'd0);
            chk("R7 ctrl write response", {31'd0, ob_resp}, 32'd1);
            xact(1'b0, ba, 32'd0);
            exp_rd = (ia[15:14] == 2'b00) ? {16'hA5A5, ia} : 32'd0;
            chk("R7 strobe one cycle after accept", {31'd0, ob_en}, 32'd1);
            chk("R7 not ready while busy", {31'd0, ob_busy}, 32'd1);
            chk("R2 R3 R5 internal offset", {16'd0, ob_addr}, {16'd0, ia});
            chk("R7 response two cycles after accept", {31'd0, ob_resp}, 32'd1);
            chk("R6 R8 read data", ob_rdata, exp_rd);
        end

        // R4 R9 writable mask and pio enables
        xact(1'b1, 12'h808, 32'hFFFF_FFFF);
        xact(1'b0, 12'h808, 32'd0);
        chk("R9 all-ones readback", ob_rdata, 32'h0007_E003);
        chk("R4 pio enables driven", {30'd0, in_pio_en, out_pio_en}, 32'd3);
        // R9 read-modify-write: change page only, keep enables
        xact(1'b1, 12'h808, (ob_rdata & ~32'h0007_E000) | (32'd2 << 13));
        xact(1'b0, 12'h808, 32'd0);
        chk("R9 rmw keeps enables", ob_rdata, 32'h0000_4003);

        // R8 write pass-through in page 2 window
        xact(1'b1, 12'hC10, 32'hDEAD_BEEF);
        chk("R8 write strobe", {31'd0, ob_en}, 32'd1);
        chk("R8 cfg_we", {31'd0, ob_we}, 32'd1);
        chk("R8 cfg_wdata", ob_wdata, 32'hDEAD_BEEF);
        chk("R3 write offset", {16'd0, ob_addr}, 32'h0000_0810);
        chk("R8 write response data", ob_rdata, 32'd0);

        // R6 write to unimplemented page still answered
        xact(1'b1, 12'h808, {13'd0, 6'd40, 13'd0});
        xact(1'b1, 12'hC00, 32'h1234_5678);
        chk("R6 miss write offset", {16'd0, ob_addr}, 32'h0000_A000);
        chk("R6 miss write response", {31'd0, ob_resp}, 32'd1);
        xact(1'b0, 12'hC08, 32'd0);
        chk("R6 miss read zero", ob_rdata, 32'd0);
        @(negedge clk);
        chk("R7 ready after response", {31'd0, req_ready}, 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule